// File: doc/BRIEF.md
# Strobed and Handshake Parallel Port

This block is an 8-bit parallel port controller. It sits on a simple register bus and has two control lines. Strobe A is an input from the peripheral. Strobe B is an output to the peripheral. Strobe A passes through a two-flop synchroniser before its edge is detected. The detected edge captures the port pins into an input latch and sets a status flag. A separate auxiliary output register drives a second byte-wide output and can announce each write with a strobe.

The port has three working modes, set by a handshake bit and a direction bit:

- **Simple strobed mode.** Strobe B announces writes to the auxiliary register.
- **Input handshake.** Strobe B acknowledges reads of the latch with a short pulse, or acts as a ready level.
- **Output handshake.** Strobe B announces writes to the port data register. It is either a short pulse, or a level held until the peripheral acknowledges on strobe A.

Firmware clears the status flag in two steps: a status read made while the flag is set, then a read of the latch.

Top module: `pp_port`

Register map (`reg_addr`):

| Address | Register | Read | Write |
|---|---|---|---|
| 0 | control | control/status byte | control byte |
| 1 | latch / port data | input latch | port data |
| 2 | direction | direction | direction |
| 3 | auxiliary output | auxiliary output | auxiliary output |

Control/status byte, bit by bit:

| Bit | Meaning | Access |
|---|---|---|
| 7 | flag | read-only |
| 6 | interrupt enable | read/write |
| 5 | overrun | read-only |
| 4 | handshake enable | read/write |
| 3 | output-direction handshake | read/write |
| 2 | pulsed (1) / interlocked (0) | read/write |
| 1 | strobe A edge: rising (1) / falling (0) | read/write |
| 0 | strobe B active level: high (1) / low (0) | read/write |

## Requirements
- R1: After reset, all of the following are zero: the control byte, direction, port data, the auxiliary output, `pins_oe`, flag, overrun and `irq`. `stb_b_out` is high, because reset selects an active-low strobe B that is idle.
- R2: The selected edge of `stb_a_in` latches `pins_in` and sets flag (bit 7). The edge is selected by bit 1: 1 = rising, 0 = falling. The flag is set at the third rising clock edge after the level change.
- R3: The flag clears only when a latch read (address 1) follows a status read (address 0) that was made while the flag was set. A latch read that is not armed this way leaves the flag set.
- R4: `irq` is high exactly when the flag and bit 6 are both set.
- R5: An active edge that arrives while the flag is set overwrites the latch and sets overrun (bit 5). The clear sequence of R3 clears overrun as well.
- R6: In simple mode (bit 4 = 0), a write to address 3 updates `aux_out` and makes strobe B active for exactly 2 cycles.
- R7: Bit 0 selects the active level of `stb_b_out`: 1 = active-high, 0 = active-low.
- R8: In pulsed input handshake (bits 4,3,2 = 1,0,1), a latch read makes strobe B active for exactly 2 cycles.
- R9: In interlocked input handshake (bits 4,3,2 = 1,0,0), strobe B is active while the flag is clear and inactive while it is set.
- R10: In output handshake (bits 4,3 = 1,1), a write to address 1 makes strobe B active. In pulsed mode (bit 2 = 1) it stays active for 2 cycles. In interlocked mode (bit 2 = 0) it stays active until the next strobe A edge.
- R11: `pins_out` shows the port data register and `pins_oe` shows the direction register, where 1 means output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_addr | input | 2 | register address |
| reg_wr | input | 1 | write strobe, one cycle |
| reg_rd | input | 1 | read strobe, one cycle (side effects) |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data, combinational |
| pins_in | input | 8 | port pin levels |
| pins_out | output | 8 | port data driven to pins |
| pins_oe | output | 8 | per-bit output enable |
| aux_out | output | 8 | auxiliary output register |
| stb_a_in | input | 1 | strobe A from peripheral, asynchronous |
| stb_b_out | output | 1 | strobe B to peripheral |
| irq | output | 1 | interrupt request |

## Verification
A strobe A level change reaches the flag, the latch, `irq` and the release of an interlocked strobe B at the third rising clock edge. The bench therefore holds each strobe level for four cycles before it reads status. A bus write or read takes effect at the clock edge that ends the access. Strobe B is sampled at that following falling edge and at the next one, where it must be active, and again one falling edge later, where it must be idle. Register reads are sampled one time unit after the address is driven, in the middle of the access cycle.

// File: rtl/pp_pkg.sv
// Package: shared register addresses and configuration layout for the
// parallel port. Assumes a 2-bit register address space.
package pp_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL  = 2'd0,
        A_LATCH = 2'd1,
        A_DIR   = 2'd2,
        A_AUX   = 2'd3
    } pp_addr_e;

    // Writable control fields; the status bits (flag, overrun) live elsewhere.
    typedef struct packed {
        logic ien;     // interrupt enable, byte bit 6
        logic hs;      // handshake enable, byte bit 4
        logic oin;     // output-direction handshake, byte bit 3
        logic pls;     // pulsed (1) or interlocked (0), byte bit 2
        logic rise;    // strobe A active on rising (1) or falling (0) edge, byte bit 1
        logic pol_hi;  // strobe B active-high (1) or active-low (0), byte bit 0
    } pp_cfg_t;
endpackage

// File: rtl/pp_sync_edge.sv
// Module: synchronises an asynchronous strobe through STAGES flops and
// flags the selected edge for one cycle. Assumes STAGES >= 2.
module pp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic rise_sel,
    output logic edge_o
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;
    logic              s_now;

    // Purpose: shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], async_in};
    end

    assign s_now = sh_q[STAGES-1];

    // Purpose: remember the last synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= s_now;
    end

    // Purpose: pick the rising or falling transition.
    always_comb begin
        edge_o = rise_sel ? (s_now & ~prev_q) : (~s_now & prev_q);
    end
endmodule

// File: rtl/pp_status.sv
// Module: input latch, status flag, overrun bit and the two-step clear.
// Assumes st_rd_i and lat_rd_i are single-cycle read strobes.
module pp_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    input  logic [DW-1:0] pins_i,
    input  logic          st_rd_i,
    input  logic          lat_rd_i,
    output logic          flag_o,
    output logic          ovr_o,
    output logic          armed_o,
    output logic [DW-1:0] latch_o
);
    logic clr;

    // Purpose: a latch read completes the clear only once armed.
    always_comb clr = lat_rd_i & armed_o;

    // Purpose: capture pins on each active strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_o <= '0;
        else if (edge_i) latch_o <= pins_i;
    end

    // Purpose: flag set by edge (edge wins over clear), cleared by sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (edge_i) flag_o <= 1'b1;
        else if (clr)    flag_o <= 1'b0;
    end

    // Purpose: note a byte lost to a second strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                ovr_o <= 1'b0;
        else if (edge_i && flag_o) ovr_o <= 1'b1;
        else if (clr)              ovr_o <= 1'b0;
    end

    // Purpose: arm the clear on a status read seen with the flag set.
    always_ff @(posedge clk) begin
        if (!rst_n)                 armed_o <= 1'b0;
        else if (clr)               armed_o <= 1'b0;
        else if (st_rd_i && flag_o) armed_o <= 1'b1;
    end
endmodule

// File: rtl/pp_strobe_gen.sv
// Module: builds strobe B from a fixed-length pulse, an interlocked hold
// and a ready level, then applies the polarity. Assumes PULSE_CYCLES >= 1.
module pp_strobe_gen #(
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic hold_set_i,
    input  logic hold_clr_i,
    input  logic level_i,
    input  logic pol_hi_i,
    output logic hold_o,
    output logic stb_o
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             act;

    // Purpose: count down the active cycles of a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (fire_i)       cnt_q <= CNT_W'(PULSE_CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
    end

    // Purpose: keep strobe active until acknowledged in interlocked output.
    always_ff @(posedge clk) begin
        if (!rst_n)          hold_o <= 1'b0;
        else if (hold_set_i) hold_o <= 1'b1;
        else if (hold_clr_i) hold_o <= 1'b0;
    end

    // Purpose: merge sources and apply polarity.
    always_comb begin
        act   = (cnt_q != '0) | hold_o | level_i;
        stb_o = pol_hi_i ? act : ~act;
    end
endmodule

// File: rtl/pp_port.sv
// Module: top of the parallel port. Decodes the register bus, holds the
// control, direction, port data and auxiliary registers, and selects the
// strobe B behaviour from the mode bits. Assumes one bus access per cycle.
module pp_port
    import pp_pkg::*;
#(
    parameter int DW           = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int PULSE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [DW-1:0]     pins_in,
    output logic [DW-1:0]     pins_out,
    output logic [DW-1:0]     pins_oe,
    output logic [DW-1:0]     aux_out,
    input  logic              stb_a_in,
    output logic              stb_b_out,
    output logic              irq
);
    pp_cfg_t       cfg_q;
    logic [DW-1:0] ddr_q, port_q, aux_q, latch;
    logic          a_edge, flag, ovr, armed, hold;
    logic          st_rd, lat_rd, wr_ctrl, wr_port, wr_dir, wr_aux;
    logic          m_simple, m_in_hs, m_out_hs;
    logic          fire, hold_set, hold_clr, ready_lvl;
    pp_addr_e      addr;

    // Purpose: decode bus accesses.
    always_comb begin
        addr    = pp_addr_e'(reg_addr);
        st_rd   = reg_rd && addr == A_CTRL;
        lat_rd  = reg_rd && addr == A_LATCH;
        wr_ctrl = reg_wr && addr == A_CTRL;
        wr_port = reg_wr && addr == A_LATCH;
        wr_dir  = reg_wr && addr == A_DIR;
        wr_aux  = reg_wr && addr == A_AUX;
    end

    // Purpose: control register (status bits are read-only).
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= '0;
        else if (wr_ctrl) cfg_q <= '{ien: reg_wdata[6], hs: reg_wdata[4],
                                     oin: reg_wdata[3], pls: reg_wdata[2],
                                     rise: reg_wdata[1], pol_hi: reg_wdata[0]};
    end

    // Purpose: direction, port data and auxiliary output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ddr_q  <= '0;
            port_q <= '0;
            aux_q  <= '0;
        end else begin
            if (wr_dir)  ddr_q  <= reg_wdata;
            if (wr_port) port_q <= reg_wdata;
            if (wr_aux)  aux_q  <= reg_wdata;
        end
    end

    pp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(stb_a_in),
        .rise_sel(cfg_q.rise), .edge_o(a_edge)
    );

    pp_status #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .edge_i(a_edge), .pins_i(pins_in),
        .st_rd_i(st_rd), .lat_rd_i(lat_rd), .flag_o(flag), .ovr_o(ovr),
        .armed_o(armed), .latch_o(latch)
    );

    // Purpose: choose which event drives strobe B in each mode.
    always_comb begin
        m_simple  = !cfg_q.hs;
        m_in_hs   = cfg_q.hs && !cfg_q.oin;
        m_out_hs  = cfg_q.hs && cfg_q.oin;
        fire      = (m_simple && wr_aux)
                  | (m_in_hs && cfg_q.pls && lat_rd)
                  | (m_out_hs && cfg_q.pls && wr_port);
        hold_set  = m_out_hs && !cfg_q.pls && wr_port;
        hold_clr  = a_edge || !(m_out_hs && !cfg_q.pls);
        ready_lvl = m_in_hs && !cfg_q.pls && !flag;
    end

    pp_strobe_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_stb (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .hold_set_i(hold_set),
        .hold_clr_i(hold_clr), .level_i(ready_lvl), .pol_hi_i(cfg_q.pol_hi),
        .hold_o(hold), .stb_o(stb_b_out)
    );

    // Purpose: read-data mux.
    always_comb begin
        unique case (addr)
            A_CTRL:  reg_rdata = {flag, cfg_q.ien, ovr, cfg_q.hs, cfg_q.oin,
                                  cfg_q.pls, cfg_q.rise, cfg_q.pol_hi};
            A_LATCH: reg_rdata = latch;
            A_DIR:   reg_rdata = ddr_q;
            default: reg_rdata = aux_q;
        endcase
    end

    // Purpose: drive pins and interrupt.
    always_comb begin
        pins_out = port_q;
        pins_oe  = ddr_q;
        aux_out  = aux_q;
        irq      = flag & cfg_q.ien;
    end
endmodule

// File: rtl/pp_port_chk.sv
// Module: property checker for pp_port, attached by bind below.
module pp_port_chk (
    input logic clk,
    input logic rst_n,
    input logic edge_pulse,
    input logic flag_q,
    input logic ovr_q,
    input logic armed_q,
    input logic lat_rd,
    input logic hold_q,
    input logic hold_set,
    input logic irq
);
    p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_pulse |=> flag_q);

    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(lat_rd && armed_q));

    p_irq_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag_q);

    p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse && flag_q) |=> ovr_q);

    p_hold_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && edge_pulse && !hold_set) |=> !hold_q);
endmodule

bind pp_port pp_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .edge_pulse(a_edge), .flag_q(flag),
    .ovr_q(ovr), .armed_q(armed), .lat_rd(lat_rd), .hold_q(hold),
    .hold_set(hold_set), .irq(irq)
);

// File: tb/pp_port_test.sv
module pp_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata, pins_in = '0;
    logic [7:0] pins_out, pins_oe, aux_out;
    logic       stb_a_in = 1'b1, stb_b_out, irq;

    int   n_run = 0, n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] cfg = '0;
    logic       m_flag = 0, m_ovr = 0, m_arm = 0;
    logic [7:0] m_latch = '0;

    always #5 clk = ~clk;

    pp_port uut (.*);

    function automatic logic [7:0] exp_status(logic f, logic o, logic [7:0] c);
        return {f, c[6], o, c[4:0]};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 2'd0) cfg = d;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_status(string tag);
        logic [7:0] d;
        rd(2'd0, d);
        check(tag, d, exp_status(m_flag, m_ovr, cfg));
        if (m_flag) m_arm = 1'b1;
    endtask

    task automatic rd_latch(string tag);
        logic [7:0] d;
        rd(2'd1, d);
        check(tag, d, m_latch);
        if (m_arm) begin m_flag = 0; m_ovr = 0; m_arm = 0; end
    endtask

    task automatic pulse_a(logic [7:0] data);
        pins_in = data;
        stb_a_in = cfg[1] ? 1'b0 : 1'b1;
        repeat (4) @(negedge clk);
        stb_a_in = ~stb_a_in;
        repeat (4) @(negedge clk);
        stb_a_in = ~stb_a_in;
        repeat (4) @(negedge clk);
        if (m_flag) m_ovr = 1'b1;
        m_flag = 1'b1; m_latch = data;
    endtask

    task automatic check_pulse(string tag, logic lvl);
        check(tag, {7'd0, stb_b_out}, {7'd0, lvl});
        @(negedge clk);
        check(tag, {7'd0, stb_b_out}, {7'd0, lvl});
        @(negedge clk);
        check(tag, {7'd0, stb_b_out}, {7'd0, ~lvl});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h1f2e3d4c));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(2'd0, d);  check("R1 ctrl", d, 8'h00);
        rd(2'd2, d);  check("R1 dir", d, 8'h00);
        check("R1 aux", aux_out, 8'h00);
        check("R1 oe", pins_oe, 8'h00);
        check("R1 pins_out", pins_out, 8'h00);
        check("R1 stb_b idle", {7'd0, stb_b_out}, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        // R11 port data and direction
        wr(2'd2, 8'hF0);
        wr(2'd1, 8'h5A);
        check("R11 pins_out", pins_out, 8'h5A);
        check("R11 oe", pins_oe, 8'hF0);
        // R6 / R7 simple strobed output, both polarities
        wr(2'd3, 8'h3C);
        check("R6 aux", aux_out, 8'h3C);
        check_pulse("R6 R7 low pulse", 1'b0);
        wr(2'd0, 8'h01);
        check("R7 idle high-pol", {7'd0, stb_b_out}, 8'h00);
        wr(2'd3, 8'hC3);
        check_pulse("R6 R7 high pulse", 1'b1);
        // R2 rising edge, R4 irq
        wr(2'd0, 8'h43);
        pulse_a(8'hA5);
        check("R4 irq set", {7'd0, irq}, 8'h01);
        // R3 unarmed latch read keeps flag
        rd_latch("R3 unarmed read");
        rd_status("R3 flag kept");
        rd_latch("R3 armed read");
        rd_status("R3 cleared");
        check("R4 irq clear", {7'd0, irq}, 8'h00);
        // R5 overrun
        pulse_a(8'h11);
        pulse_a(8'h22);
        rd_status("R5 overrun status");
        rd_latch("R5 newest byte");
        rd_status("R5 cleared");
        // R8 pulsed input handshake
        wr(2'd0, 8'h15);
        rd_latch("R8 latch");
        check_pulse("R8 ack pulse", 1'b1);
        // R9 interlocked input handshake
        wr(2'd0, 8'h11);
        check("R9 ready", {7'd0, stb_b_out}, 8'h01);
        pulse_a(8'h77);
        check("R9 not ready", {7'd0, stb_b_out}, 8'h00);
        rd_status("R9 status");
        rd_latch("R9 latch");
        check("R9 ready again", {7'd0, stb_b_out}, 8'h01);
        // R10 output handshake pulsed then interlocked
        wr(2'd0, 8'h1D);
        wr(2'd1, 8'h99);
        check_pulse("R10 pulsed", 1'b1);
        check("R10 R11 data", pins_out, 8'h99);
        wr(2'd0, 8'h19);
        wr(2'd1, 8'h42);
        check("R10 hold on", {7'd0, stb_b_out}, 8'h01);
        repeat (6) @(negedge clk);
        check("R10 hold stays", {7'd0, stb_b_out}, 8'h01);
        pulse_a(8'h00);
        check("R10 released", {7'd0, stb_b_out}, 8'h00);
        rd_status("R10 status");
        rd_latch("R10 latch");
        // Random mix, falling-edge mode with interrupts (R2 R3 R4 R5)
        wr(2'd0, 8'h40);
        for (int i = 0; i < 80; i++) begin
            case ($urandom_range(0, 2))
                0: pulse_a(8'($urandom()));
                1: rd_status("R2 R5 random status");
                default: rd_latch("R3 random latch");
            endcase
            check("R4 random irq", {7'd0, irq}, {7'd0, m_flag});
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule